// File: doc/BRIEF.md
# Ethernet Frame Decapsulation Ingress Buffer

This block sits between the receive side of an Ethernet MAC and an IPv4 forwarding core. Bytes arrive one per cycle on a valid/ready stream with start-of-packet and end-of-packet markers. The block keeps exactly one frame in a local byte store sized for the longest legal frame. Nothing leaves until the final byte of that frame has been written. The frame is then read out on a valid/ready byte stream with a last marker. The 14-byte link header (destination address, source address, EtherType) is skipped, and the 4 trailing check-sequence bytes are never presented, so the core receives only the IP datagram.

The input side models a MAC that cannot be stalled. `in_ready` is advisory. It is high while the store is free and low from the cycle after a frame is accepted for forwarding until the cycle after its last output byte is taken. Bytes offered while `in_ready` is low are lost. A frame whose start byte is offered then is counted as dropped. Frames with the wrong EtherType or an illegal length are also discarded and counted.

On the output side, the consumer may hold `out_ready` low for any number of cycles. While it does, `out_valid`, `out_data` and `out_last` stay unchanged. Two free-running counters report dropped and forwarded frames.

Top module: `eth_decap_ingress`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, and both counters are 0.
- R2: `in_ready` is 0 from the cycle after an end byte that completes a forwardable frame. It returns to 1 in the cycle after the handshake on the byte with `out_last`.
- R3: No output byte is offered before the whole frame is stored. `out_valid` rises in the cycle after the end byte of a forwardable frame.
- R4: The output bytes are frame bytes 14 through L-5 (L is the frame length, byte 0 is the start byte), in arrival order. Frame bytes 0 to 13 are never output.
- R5: `out_last` is 1 only on frame byte L-5, so none of the last 4 bytes is output.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_last` hold their values into the next cycle.
- R7: A frame whose byte 12 and byte 13, read as a big-endian 16-bit value, differ from 0x0800 produces no output and adds 1 to `drop_count`.
- R8: A start byte offered with `in_valid` while `in_ready` is 0 adds 1 to `drop_count`. That frame produces no output.
- R9: A frame shorter than 64 bytes or longer than 1518 bytes produces no output and adds 1 to `drop_count`.
- R10: `fwd_count` rises by 1 in the cycle after the handshake on a byte with `out_last`, and at no other time.
- R11: Bytes offered while `in_ready` is 1 but outside a frame (no accepted start byte since the last end byte) are ignored. They do not change the output or either counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present this cycle |
| in_ready | output | 1 | Store is free; input bytes are taken |
| in_data | input | 8 | Input frame byte |
| in_sop | input | 1 | Input byte is the first of a frame |
| in_eop | input | 1 | Input byte is the last of a frame |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Consumer takes the output byte |
| out_data | output | 8 | Datagram byte |
| out_last | output | 1 | Final datagram byte of the frame |
| drop_count | output | CNT_W | Frames discarded, wraps |
| fwd_count | output | CNT_W | Frames forwarded, wraps |

## Verification
The output assertions depend on one input property. A start byte never arrives while a frame is still being written, so every accepted frame ends with exactly one end byte before the next one begins. The drop assertion counts one drop per start byte offered while busy, so it also depends on each start byte lasting exactly one cycle. The stimulus keeps within these limits. It builds every frame as one unbroken burst with a single start and end byte, and it never holds a start byte across cycles. Stray bytes are sent with no start byte, and frames are sent into a busy store only as whole bursts.

// File: rtl/efd_pkg.sv
package efd_pkg;
  // Link header length; the datagram starts at this byte index.
  localparam int HDR_BYTES   = 14;
  // Trailing check-sequence length that is never forwarded.
  localparam int FCS_BYTES   = 4;
  // Byte indices carrying the big-endian protocol type.
  localparam int TYPE_HI_IDX = 12;
  localparam int TYPE_LO_IDX = 13;
  // Protocol type value accepted for forwarding.
  localparam logic [15:0] TYPE_IPV4 = 16'h0800;
endpackage

// File: rtl/efd_frame_mem.sv
module efd_frame_mem #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1518,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] store [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  // Unregistered read keeps the output stream free of a prefetch stage.
  assign rd_data = store[rd_addr];
endmodule

// File: rtl/efd_fill_ctrl.sv
module efd_fill_ctrl
  import efd_pkg::*;
#(
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1518,
  parameter int ADDR_W    = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_ready,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [7:0]        in_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              commit,
  output logic [ADDR_W-1:0] commit_last,
  output logic              reject
);
  localparam logic [ADDR_W-1:0] MAX_A  = ADDR_W'(MAX_FRAME);
  localparam logic [ADDR_W-1:0] MINI_A = ADDR_W'(MIN_FRAME - 1);
  localparam logic [ADDR_W-1:0] HI_A   = ADDR_W'(TYPE_HI_IDX);
  localparam logic [ADDR_W-1:0] LO_A   = ADDR_W'(TYPE_LO_IDX);
  localparam logic [ADDR_W-1:0] FCS_A  = ADDR_W'(FCS_BYTES);

  logic              active;
  logic [ADDR_W-1:0] wr_ptr;
  logic              ovf;
  logic [7:0]        type_hi, type_lo;

  logic              take;
  logic [ADDR_W-1:0] idx;
  logic              in_range, ovf_eff, len_ok, type_ok;

  always_comb begin
    take     = in_valid && in_ready && (in_sop || active);
    idx      = in_sop ? '0 : wr_ptr;
    in_range = idx < MAX_A;
    ovf_eff  = (!in_sop && ovf) || !in_range;
    len_ok   = (idx >= MINI_A) && !ovf_eff;
    type_ok  = {type_hi, type_lo} == TYPE_IPV4;
  end

  assign wr_en       = take && in_range;
  assign wr_addr     = idx;
  assign wr_data     = in_data;
  assign commit      = take && in_eop && len_ok && type_ok;
  assign reject      = take && in_eop && !(len_ok && type_ok);
  assign commit_last = idx - FCS_A;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      wr_ptr  <= '0;
      ovf     <= 1'b0;
      type_hi <= '0;
      type_lo <= '0;
    end else if (take) begin
      active <= !in_eop;
      wr_ptr <= in_range ? idx + 1'b1 : idx;
      ovf    <= ovf_eff;
      if (idx == HI_A) type_hi <= in_data;
      if (idx == LO_A) type_lo <= in_data;
    end
  end

  // R11: outside a frame only a start byte may write the store
  a_r11_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !(in_valid && in_ready && in_sop)) |-> !wr_en);

  // R9: a committed frame always ends inside the legal window
  a_r9_commit_window: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (commit_last >= MINI_A - FCS_A) && (commit_last < MAX_A - FCS_A));
endmodule

// File: rtl/efd_drain_ctrl.sv
module efd_drain_ctrl
  import efd_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [ADDR_W-1:0] commit_last,
  input  logic              out_ready,
  input  logic [7:0]        rd_data,
  output logic              full,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              done
);
  localparam logic [ADDR_W-1:0] HDR_A = ADDR_W'(HDR_BYTES);

  logic [ADDR_W-1:0] rd_ptr;
  logic [ADDR_W-1:0] last_idx;
  logic              fire;

  assign out_valid = full;
  assign out_data  = rd_data;
  assign out_last  = full && (rd_ptr == last_idx);
  assign rd_addr   = rd_ptr;
  assign fire      = full && out_ready;
  assign done      = fire && out_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full     <= 1'b0;
      rd_ptr   <= HDR_A;
      last_idx <= '0;
    end else if (commit) begin
      full     <= 1'b1;
      rd_ptr   <= HDR_A;
      last_idx <= commit_last;
    end else if (fire) begin
      if (out_last) full <= 1'b0;
      else          rd_ptr <= rd_ptr + 1'b1;
    end
  end

  // R2: the fill side never loads a frame while one is still draining
  a_r2_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !full);

  // R4: reads stay between the end of the header and the last datagram byte
  a_r4_read_window: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (rd_ptr >= HDR_A) && (rd_ptr <= last_idx));

  // R6: a stalled byte holds
  a_r6_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid && $stable(out_data) && $stable(out_last));

  // R5: the last byte ends the frame
  a_r5_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> !out_valid);
endmodule

// File: rtl/eth_decap_ingress.sv
module eth_decap_ingress #(
  parameter int MIN_FRAME = 64,
  parameter int MAX_FRAME = 1518,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sop,
  input  logic             in_eop,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic [CNT_W-1:0] drop_count,
  output logic [CNT_W-1:0] fwd_count
);
  localparam int ADDR_W = $clog2(MAX_FRAME + 1);

  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [7:0]        wr_data;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        rd_data;
  logic              commit, reject, full, done;
  logic [ADDR_W-1:0] commit_last;
  logic              busy_drop;

  assign in_ready  = !full;
  assign busy_drop = in_valid && in_sop && !in_ready;

  efd_fill_ctrl #(
    .MIN_FRAME (MIN_FRAME),
    .MAX_FRAME (MAX_FRAME),
    .ADDR_W    (ADDR_W)
  ) u_fill (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .in_sop      (in_sop),
    .in_eop      (in_eop),
    .in_data     (in_data),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .commit      (commit),
    .commit_last (commit_last),
    .reject      (reject)
  );

  efd_frame_mem #(
    .DATA_W (8),
    .DEPTH  (MAX_FRAME),
    .ADDR_W (ADDR_W)
  ) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  efd_drain_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_drain (
    .clk         (clk),
    .rst_n       (rst_n),
    .commit      (commit),
    .commit_last (commit_last),
    .out_ready   (out_ready),
    .rd_data     (rd_data),
    .full        (full),
    .rd_addr     (rd_addr),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_last    (out_last),
    .done        (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drop_count <= '0;
      fwd_count  <= '0;
    end else begin
      if (reject || busy_drop) drop_count <= drop_count + 1'b1;
      if (done)                fwd_count  <= fwd_count + 1'b1;
    end
  end

  // R10: one forwarded count per final handshake
  a_r10_fwd_step: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> fwd_count == $past(fwd_count) + 1'b1);

  // R8: a start byte offered while busy is counted
  a_r8_busy_drop: assert property (@(posedge clk) disable iff (!rst_n)
    busy_drop |=> drop_count == $past(drop_count) + 1'b1);

  // R3: output only appears after a frame is committed
  a_r3_store_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(commit));
endmodule

// File: tb/tb_eth_decap_ingress.sv
`timescale 1ns/1ps
module tb_eth_decap_ingress;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic [7:0]       in_data = '0;
  logic             in_sop = 1'b0;
  logic             in_eop = 1'b0;
  logic             out_valid;
  logic             out_ready = 1'b1;
  logic [7:0]       out_data;
  logic             out_last;
  logic [CNT_W-1:0] drop_count;
  logic [CNT_W-1:0] fwd_count;

  int checks = 0;
  int fails  = 0;
  int rdy_mode = 0;  // 0 always ready, 1 pseudo-random, 2 stalled
  bit finished = 0;

  always #2.5 clk = ~clk;

  eth_decap_ingress #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .drop_count(drop_count), .fwd_count(fwd_count)
  );

  // Behavioural reference state
  logic [7:0] m_q[$];
  logic [7:0] m_rx[$];
  bit m_full = 0, m_act = 0;
  int m_drop = 0, m_fwd = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q.delete(); m_rx.delete();
      m_full = 0; m_act = 0; m_drop = 0; m_fwd = 0;
    end else begin
      bit old_full;
      old_full = m_full;
      if (m_full && out_ready) begin
        if (m_q.size() == 1) begin m_full = 0; m_fwd++; end
        void'(m_q.pop_front());
      end
      if (in_valid && in_sop && old_full) m_drop++;
      if (in_valid && !old_full) begin
        if (in_sop) begin m_rx.delete(); m_act = 1; end
        if (m_act) begin
          m_rx.push_back(in_data);
          if (in_eop) begin
            int n;
            m_act = 0;
            n = m_rx.size();
            if (n >= 64 && n <= 1518 && m_rx[12] == 8'h08 && m_rx[13] == 8'h00) begin
              m_q.delete();
              for (int k = 14; k <= n - 5; k++) m_q.push_back(m_rx[k]);
              m_full = 1;
            end else m_drop++;
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(in_ready == !m_full, "R2 in_ready", int'(in_ready), int'(!m_full));
      chk(out_valid == m_full, "R3 out_valid", int'(out_valid), int'(m_full));
      if (m_full && m_q.size() > 0) begin
        chk(out_data == m_q[0], "R4 out_data", int'(out_data), int'(m_q[0]));
        chk(out_last == (m_q.size() == 1), "R5 out_last", int'(out_last), int'(m_q.size() == 1));
      end
      chk(int'(drop_count) == m_drop, "R7/R8/R9 drop_count", int'(drop_count), m_drop);
      chk(int'(fwd_count) == m_fwd, "R10 fwd_count", int'(fwd_count), m_fwd);
    end
  end

  always @(negedge clk) begin
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = 1'($urandom % 2);
      default: out_ready = 1'b0;
    endcase
  end

  function automatic logic [7:0] byte_of(int i, logic [15:0] et, int seed);
    if (i < 6)       return 8'(8'hA0 + i);
    else if (i < 12) return 8'(8'hB0 + i);
    else if (i == 12) return et[15:8];
    else if (i == 13) return et[7:0];
    else             return 8'(seed + i * 7);
  endfunction

  task automatic send_frame(int len, logic [15:0] et, int seed);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sop   = (i == 0);
      in_eop   = (i == len - 1);
      in_data  = byte_of(i, et, seed);
    end
  endtask

  task automatic idle(int n);
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_drained();
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk);
      if (in_ready && !m_full) break;
    end
  endtask

  task automatic report();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(drop_count == 0, "R1 drop_count", int'(drop_count), 0);
    chk(fwd_count == 0, "R1 fwd_count", int'(fwd_count), 0);

    // Minimum length frame
    rdy_mode = 0;
    send_frame(64, 16'h0800, 3);
    idle(1);
    // R3: out_valid high the cycle after the end byte
    chk(out_valid == 1'b1, "R3 valid after eop", int'(out_valid), 1);
    chk(out_data == byte_of(14, 16'h0800, 3), "R4 first byte", int'(out_data), int'(byte_of(14, 16'h0800, 3)));
    wait_drained();

    // Maximum length frame with random back-pressure
    rdy_mode = 1;
    send_frame(1518, 16'h0800, 11);
    idle(1);
    wait_drained();
    rdy_mode = 0;
    chk(fwd_count == 2, "R10 two forwarded", int'(fwd_count), 2);

    // Wrong protocol type
    send_frame(200, 16'h86DD, 5);
    idle(5);
    chk(drop_count == 1, "R7 type drop", int'(drop_count), 1);
    chk(out_valid == 1'b0, "R7 no output", int'(out_valid), 0);

    // Illegal lengths
    send_frame(40, 16'h0800, 7);
    idle(3);
    send_frame(1530, 16'h0800, 9);
    idle(3);
    chk(drop_count == 3, "R9 length drops", int'(drop_count), 3);
    chk(fwd_count == 2, "R9 nothing forwarded", int'(fwd_count), 2);

    // Stall, then offer a frame while busy
    rdy_mode = 2;
    send_frame(100, 16'h0800, 21);
    idle(3);
    held = out_data;
    idle(40);
    chk(out_valid == 1'b1 && out_data == held, "R6 stalled byte held", int'(out_data), int'(held));
    chk(held == byte_of(14, 16'h0800, 21), "R4 header skipped", int'(held), int'(byte_of(14, 16'h0800, 21)));
    send_frame(80, 16'h0800, 33);
    idle(2);
    chk(drop_count == 4, "R8 busy drop", int'(drop_count), 4);
    rdy_mode = 0;
    wait_drained();

    // Stray bytes with no start byte
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b0; in_eop = (i == 9); in_data = 8'(i);
    end
    idle(4);
    chk(drop_count == 4 && out_valid == 1'b0, "R11 stray ignored", int'(drop_count), 4);
    send_frame(128, 16'h0800, 41);
    idle(1);
    wait_drained();
    chk(fwd_count == 4, "R11 later frame forwarded", int'(fwd_count), 4);

    // Back-to-back frames: the second lands while busy
    send_frame(70, 16'h0800, 51);
    send_frame(70, 16'h0800, 61);
    idle(1);
    wait_drained();
    idle(2);
    chk(drop_count == 5, "R8 back-to-back drop", int'(drop_count), 5);
    chk(fwd_count == 5, "R10 final forwarded", int'(fwd_count), 5);
    chk(in_ready == 1'b1, "R2 ready after drain", int'(in_ready), 1);

    report();
  end
endmodule